// File: doc/BRIEF.md
# Lockable Single-Channel PWM Timer

This block is a one-channel pulse-width modulator that sits behind a plain memory-mapped register port with a 32-bit data path. Software programs a period and a duty value, both counted in cycles of the block clock, and a control word. The control word starts the timer, picks the output level for the duty phase and for the rest of the period, and can hold an update lock. The block drives a single output pin.

Written period, duty and level settings first land in shadow registers. They are copied into the working set as one group, and only at a period boundary, so a running waveform never shows a half-updated period. While the lock bit is set, the working set does not change at all. Software can stage all three settings under the lock and then clear it, and the new group takes effect at the next boundary. While stopped, the working set follows the shadow registers, so settings written together with the start bit apply from the first period.

Top module: `pwm_lockable`

## Requirements
- R1: After reset every register reads 0 and the output is low.
- R2: Address 0x4 (period), 0x8 (duty) and 0xC (control) read back the last value written to them. Address 0x0 reads the live count.
- R3: The timer runs only when control bit 0 and control bit 1 are both 1. Otherwise the count is held at 0 and the output sits at the idle level.
- R4: While running, the count steps from 0 to period−1 and then returns to 0. A period of 0 or 1 keeps the count at 0.
- R5: While running, the output is at the active level in every cycle where count < duty. Any duty ≥ period gives the active level for the whole period, and a duty of 0 never gives it.
- R6: Control bit 3 gives the active level and control bit 4 gives the idle level (1 = high). Inverted use is bit 3 = 0 with bit 4 = 1.
- R7: While running and unlocked, a new period, duty or level setting takes effect only at the next return of the count to 0, never inside a period.
- R8: While control bit 6 (lock) is 1, the working period, duty and levels do not change, whatever is written.
- R9: Once the lock is cleared, the staged period, duty and levels all take effect together at the next period boundary.
- R10: While stopped and unlocked, the working set follows the written values, so settings written with the start bits apply from the first running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the PWM count clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | 4 | Byte address of the written register |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Byte address of the read register |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pwm_out | output | 1 | PWM output |

## Verification
Two events can fall in the same cycle: a register write and the period boundary at which the working set reloads, and also a lock change and a pending group of staged settings. The bench writes a new duty partway through a running period and checks that the rest of that period keeps the old waveform while the next one shows the new duty. It then stages a new period, duty and inverted levels under the lock across a wrap, and clears the lock one cycle before a boundary. The sample just before the wrap must still show the old waveform, and the first full period after it must show all three new settings at once.

// File: rtl/pwm_lk_pkg.sv
// Package: shared widths, register offsets, control bit positions and the
// working-set type of the lockable PWM timer.
package pwm_lk_pkg;
    localparam int DW = 32;                 // data path and counter width
    localparam int AW = 4;                  // byte address width

    localparam logic [AW-1:0] OFS_COUNT  = 4'h0;
    localparam logic [AW-1:0] OFS_PERIOD = 4'h4;
    localparam logic [AW-1:0] OFS_DUTY   = 4'h8;
    localparam logic [AW-1:0] OFS_CTRL   = 4'hC;

    localparam int CB_START = 0;            // timer start
    localparam int CB_CONT  = 1;            // continuous operation
    localparam int CB_ACTHI = 3;            // level during duty phase
    localparam int CB_IDLHI = 4;            // level outside duty phase
    localparam int CB_LOCK  = 6;            // freeze the working set

    // Settings that move from shadow to working set as one group
    typedef struct packed {
        logic [DW-1:0] period;
        logic [DW-1:0] duty;
        logic          act_hi;
        logic          idle_hi;
    } wave_cfg_t;
endpackage

// File: rtl/pwm_lk_regs.sv
// Register file of the PWM timer.
// Holds the shadow period, duty and control words, serves reads, and hands
// the core the values they take after this cycle's write (next-state view).
// Assumes at most one write per cycle; reads are combinational.
module pwm_lk_regs
    import pwm_lk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] count,
    output logic [DW-1:0] rd_data,
    output wave_cfg_t     shadow_nxt,
    output logic          lock_nxt,
    output logic          running
);
    logic [DW-1:0] period_q, duty_q, ctrl_q;
    logic [DW-1:0] period_d, duty_d, ctrl_d;

    // Next-state of each shadow register after a possible write
    always_comb begin
        period_d = period_q;
        duty_d   = duty_q;
        ctrl_d   = ctrl_q;
        if (wr_en) begin
            case (wr_addr)
                OFS_PERIOD: period_d = wr_data;
                OFS_DUTY:   duty_d   = wr_data;
                OFS_CTRL:   ctrl_d   = wr_data;
                default:    ;
            endcase
        end
    end

    // Shadow register storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            duty_q   <= '0;
            ctrl_q   <= '0;
        end else begin
            period_q <= period_d;
            duty_q   <= duty_d;
            ctrl_q   <= ctrl_d;
        end
    end

    // Read multiplexer
    always_comb begin
        case (rd_addr)
            OFS_COUNT:  rd_data = count;
            OFS_PERIOD: rd_data = period_q;
            OFS_DUTY:   rd_data = duty_q;
            OFS_CTRL:   rd_data = ctrl_q;
            default:    rd_data = '0;
        endcase
    end

    assign shadow_nxt = '{period: period_d, duty: duty_d,
                          act_hi: ctrl_d[CB_ACTHI], idle_hi: ctrl_d[CB_IDLHI]};
    assign lock_nxt   = ctrl_d[CB_LOCK];
    assign running    = ctrl_q[CB_START] & ctrl_q[CB_CONT];

    // R2: a period write is visible in the register on the following cycle
    a_r2_period_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_PERIOD) |=> (period_q == $past(wr_data)));

    // R2: a duty write is visible in the register on the following cycle
    a_r2_duty_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_DUTY) |=> (duty_q == $past(wr_data)));
endmodule

// File: rtl/pwm_lk_core.sv
// Counter and waveform core of the PWM timer.
// Counts 0..period-1 while running, reloads the working set from the shadow
// view at each boundary (or every cycle while stopped) unless locked, and
// forms the left-aligned output. Assumes the shadow view is next-state.
module pwm_lk_core
    import pwm_lk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic          lock_nxt,
    input  wave_cfg_t     shadow_nxt,
    output logic [DW-1:0] count,
    output logic          pwm_out
);
    wave_cfg_t work_q;
    logic      wrap;
    logic      load;

    // Boundary: last count of the period; period 0 behaves as period 1
    assign wrap = ({1'b0, count} + (DW+1)'(1)) >= {1'b0, work_q.period};
    assign load = !lock_nxt && (!running || wrap);

    // Period counter, held at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !running || wrap) count <= '0;
        else                            count <= count + DW'(1);
    end

    // Working set, reloaded as one group at a boundary or while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)    work_q <= '0;
        else if (load) work_q <= shadow_nxt;
    end

    // Left-aligned output: active phase first, idle level when stopped
    always_comb begin
        if (running && (count < work_q.duty)) pwm_out = work_q.act_hi;
        else                                  pwm_out = work_q.idle_hi;
    end

    // R3: a stopped timer leaves the count at zero
    a_r3_stopped_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (count == '0));

    // R4: the count never reaches the working period
    a_r4_count_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        (running && work_q.period != '0) |-> (count < work_q.period));

    // R7: inside a running period the working set does not move
    a_r7_no_midperiod_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> $stable(work_q));

    // R8: with the lock held the working set is frozen
    a_r8_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        lock_nxt |=> $stable(work_q));
endmodule

// File: rtl/pwm_lockable.sv
// Top of the lockable single-channel PWM timer.
// Joins the register file to the counter/waveform core. Assumes one clock for
// bus and count (prescale of one) and a write strobe of one cycle per access.
module pwm_lockable
    import pwm_lk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          pwm_out
);
    wave_cfg_t     shadow_nxt;
    logic          lock_nxt;
    logic          running;
    logic [DW-1:0] count;

    pwm_lk_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .count      (count),
        .rd_data    (rd_data),
        .shadow_nxt (shadow_nxt),
        .lock_nxt   (lock_nxt),
        .running    (running)
    );

    pwm_lk_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .lock_nxt   (lock_nxt),
        .shadow_nxt (shadow_nxt),
        .count      (count),
        .pwm_out    (pwm_out)
    );
endmodule

// File: tb/pwm_lockable_bench.sv
// Bench for the lockable PWM timer: a vector table of waveform settings,
// then directed tests for reset, readback, start gating, mid-period update
// and the lock sequence.
module pwm_lockable_bench;
    import pwm_lk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;

    // Each entry: {period, duty, control, expected cycles with output high}
    localparam logic [127:0] VEC [NVEC] = '{
        {32'd10, 32'd3,  32'h0B, 32'd3},
        {32'd10, 32'd0,  32'h0B, 32'd0},
        {32'd10, 32'd10, 32'h0B, 32'd10},
        {32'd10, 32'd15, 32'h0B, 32'd10},
        {32'd8,  32'd3,  32'h13, 32'd5},
        {32'd1,  32'd1,  32'h0B, 32'd1},
        {32'd6,  32'd5,  32'h13, 32'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    pwm_lockable u_pwm_lockable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    // Sample n cycles at falling edges; count highs and keep the first level
    task automatic sample(input int n, output int highs, output logic first);
        highs = 0; first = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) first = pwm_out;
            if (pwm_out) highs++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run did not end)");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        int            h;
        logic          f;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(OFS_COUNT, v);  check("R1 count", v, 0);
        rd(OFS_PERIOD, v); check("R1 period", v, 0);
        rd(OFS_DUTY, v);   check("R1 duty", v, 0);
        rd(OFS_CTRL, v);   check("R1 ctrl", v, 0);
        check("R1 out", pwm_out, 0);

        // R2: readback of written values
        wr(OFS_PERIOD, 32'd10);
        wr(OFS_DUTY, 32'd3);
        wr(OFS_CTRL, 32'h0000_0008);
        rd(OFS_PERIOD, v); check("R2 period", v, 10);
        rd(OFS_DUTY, v);   check("R2 duty", v, 3);
        rd(OFS_CTRL, v);   check("R2 ctrl", v, 32'h8);

        // R3: start bit alone does not run the timer
        wr(OFS_CTRL, 32'h0000_0009);
        sample(4, h, f);
        rd(OFS_COUNT, v); check("R3 count held", v, 0);
        check("R3 idle low", h, 0);
        // R3/R6: continuous bit alone, idle level high
        wr(OFS_CTRL, 32'h0000_0012);
        sample(4, h, f);
        rd(OFS_COUNT, v); check("R3 count held b1", v, 0);
        check("R6 idle high stopped", h, 4);

        // R4/R5/R6/R10: vector table
        for (int k = 0; k < NVEC; k++) begin
            logic [31:0] p, d, c, e;
            {p, d, c, e} = VEC[k];
            wr(OFS_CTRL, 32'h0);
            wr(OFS_PERIOD, p);
            wr(OFS_DUTY, d);
            wr(OFS_CTRL, c);
            sample(int'(p), h, f);
            check($sformatf("R5 highs vec%0d", k), h, e);
            check($sformatf("R10 first level vec%0d", k), f,
                  (d != 0) ? c[CB_ACTHI] : c[CB_IDLHI]);
            rd(OFS_COUNT, v);
            check($sformatf("R4 count vec%0d", k), v, p - 1);
        end

        // R7: duty write inside a running period
        wr(OFS_CTRL, 32'h0);
        wr(OFS_PERIOD, 32'd10);
        wr(OFS_DUTY, 32'd3);
        wr(OFS_CTRL, 32'h0B);
        sample(5, h, f);                 // counts 0..4
        check("R7 before write", h, 3);
        wr(OFS_DUTY, 32'd8);             // lands between counts 4 and 5
        sample(5, h, f);                 // counts 5..9, old duty
        check("R7 rest of period", h, 0);
        sample(10, h, f);                // next period, new duty
        check("R7 next period", h, 8);

        // R8: stage period, duty and inverted levels under the lock
        wr(OFS_CTRL, 32'h4B);            // lock, at the wrap edge
        wr(OFS_PERIOD, 32'd6);
        wr(OFS_DUTY, 32'd2);
        wr(OFS_CTRL, 32'h53);            // still locked, inverted levels
        sample(7, h, f);                 // counts 3..9
        check("R8 locked rest", h, 5);
        sample(9, h, f);                 // counts 0..8 across a wrap
        check("R8 locked next period", h, 8);
        rd(OFS_PERIOD, v); check("R2 staged period", v, 6);

        // R9: clear the lock one cycle before the boundary
        wr(OFS_CTRL, 32'h13);
        sample(1, h, f);                 // count 9, old set
        check("R9 old set before boundary", h, 0);
        sample(6, h, f);                 // new period 6, duty 2, inverted
        check("R9 new highs", h, 4);
        check("R9 new active low", f, 0);
        rd(OFS_COUNT, v); check("R9 new period wrap", v, 5);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule